// File: doc/BRIEF.md
# Pipelined Interrupt Sequencing Controller

This block decides when a pending interrupt may enter the instruction stream of a simple fetch/decode/execute pipeline. It takes maskable requests, each tagged with a 2-bit priority level, and two exception classes that the mask cannot block: an illegal-instruction fault and a conditional trap. A third exception, the stack fault, is raised inside the block. When one of these requests is accepted, the block spends two control cycles on it. It then takes over fetch for two cycles and supplies the two vector words of the winning source.

The vector words may contain a subroutine call. When the core decodes such a call among the first two decodes after the block accepts a request, the service becomes a long one. The block then writes the status-register mask to the serviced level and asks for the return context to be pushed. A return-from-interrupt decode asks for the context to be popped. A small depth counter turns an overflow or underflow of the context stack into a stack-fault request.

Nested service waits for a minimum number of decoded instructions. No service starts while an instruction after a repeat prefix is being repeated. After the loop counter reaches one, two more instructions are decoded before service can start.

Top module: `irq_seq_ctrl`

## Requirements
- R1: After reset, `fetch_vec`, `irq_ack`, `exc_ack`, `mask_wr`, `stk_push` and `stk_pop` are all low.
- R2: A maskable request is accepted only when its level (2-bit, 0 lowest, 3 highest) is strictly greater than `sr_mask`.
- R3: The illegal fault and the trap are accepted whatever `sr_mask` holds. The fixed order is stack fault, then illegal, then trap, then maskable sources. Among maskable sources the higher level wins, and on a tie the lower source number wins.
- R4: A request is accepted at a clock edge. Its acknowledge is high for the next cycle only: `irq_ack[i]` for source i, `exc_ack[0]` for illegal, `exc_ack[1]` for trap. One more control cycle follows. Then `fetch_vec` is high for two cycles with `vec_addr` = VEC_BASE + 2*n and then VEC_BASE + 2*n + 1. Here n is 0 for the stack fault, 1 for illegal, 2 for trap, and 3+i for maskable source i.
- R5: A decode with `call_dec` set, among the first two decodes counted from the acceptance edge, raises `mask_wr` and `stk_push` in the same cycle. `mask_val` is the serviced level, or 3 for an exception. This happens only once per service.
- R6: A `call_dec` decode after those first two decodes has no effect on `mask_wr` or `stk_push`.
- R7: After an acceptance, no new request is accepted until SPACING+2 decodes (default 6) have been counted since the acceptance edge.
- R8: No request is accepted while `rep_run` is high.
- R9: After a cycle with `rep_run` and `lc_one` both high, two more decodes must be counted before any request is accepted.
- R10: A decode with `rti_dec` set raises `stk_pop` in the same cycle when the stack is not empty.
- R11: A push at STK_DEPTH entries or a pop at zero entries is suppressed. It raises a stack-fault request from the next cycle, which is then serviced as vector index 0 with no acknowledge pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Maskable request per source, held until acknowledged |
| irq_lvl | input | 2*NSRC | Priority level of each source, 2 bits per source |
| sr_mask | input | 2 | Current mask field of the status register |
| exc_illegal | input | 1 | Illegal-instruction fault request (not maskable) |
| exc_trap | input | 1 | Conditional trap request (not maskable) |
| dec_strobe | input | 1 | One instruction decoded this cycle |
| call_dec | input | 1 | Decoded word is a subroutine call |
| rti_dec | input | 1 | Decoded word is a return from interrupt |
| rep_run | input | 1 | A repeated instruction is in progress |
| lc_one | input | 1 | Loop counter has reached one |
| irq_ack | output | NSRC | One-cycle acknowledge of a maskable source |
| exc_ack | output | 2 | One-cycle acknowledge: bit 0 illegal, bit 1 trap |
| fetch_vec | output | 1 | Fetch takes `vec_addr` instead of the program counter |
| vec_addr | output | AW | Vector word address, valid with `fetch_vec` |
| mask_wr | output | 1 | Write `mask_val` into the status-register mask |
| mask_val | output | 2 | New mask level |
| stk_push | output | 1 | Push program counter and status register |
| stk_pop | output | 1 | Pop program counter and status register |

## Verification
A wrong decode counter shows up as an acknowledge one cycle early or late, relative to the last decode strobe of the spacing window or of the post-repeat window. A corrupt stored source index shows up two cycles after the acknowledge as a wrong `vec_addr`. A stale service flag shows up in the very cycle of the call decode, as a missing or extra `mask_wr`/`stk_push`. A wrong depth count shows up first at the overflow or underflow edge, as a missing stack-fault vector fetch about six cycles later.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   localparam int unsigned EXC_N    = 3;
   localparam int unsigned EXC_STK  = 0;
   localparam int unsigned EXC_ILL  = 1;
   localparam int unsigned EXC_TRAP = 2;

   typedef logic [1:0] lvl_t;
   localparam lvl_t LVL_TOP = 2'd3;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CTL1,
      SQ_CTL2,
      SQ_VEC0,
      SQ_VEC1
   } sq_state_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
   import irq_seq_pkg::*;
#(
   parameter int unsigned NSRC          = 4,
   parameter int unsigned IW            = 3,
   parameter bit          TIE_LOW_FIRST = 1'b1,
   localparam int unsigned SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]   req,
   input  logic [2*NSRC-1:0] lvl_flat,
   input  lvl_t              mask,
   input  logic [EXC_N-1:0]  exc,
   output logic              hit,
   output logic              hit_src,
   output logic [SW-1:0]     src,
   output logic [IW-1:0]     idx,
   output lvl_t              lvl
);
   lvl_t            lvl_a [NSRC];
   logic [NSRC-1:0] elig;
   logic            m_hit;
   logic [SW-1:0]   m_idx;
   lvl_t            m_lvl;

   for (genvar i = 0; i < NSRC; i++) begin : g_elig
      assign lvl_a[i] = lvl_flat[2*i +: 2];
      assign elig[i]  = req[i] && (lvl_a[i] > mask);
   end

   if (TIE_LOW_FIRST) begin : g_tie_low
      always_comb begin
         m_hit = 1'b0;
         m_idx = '0;
         m_lvl = '0;
         for (int k = NSRC - 1; k >= 0; k--) begin
            if (elig[k] && (!m_hit || lvl_a[k] >= m_lvl)) begin
               m_hit = 1'b1;
               m_idx = SW'(k);
               m_lvl = lvl_a[k];
            end
         end
      end
   end else begin : g_tie_high
      always_comb begin
         m_hit = 1'b0;
         m_idx = '0;
         m_lvl = '0;
         for (int k = 0; k < NSRC; k++) begin
            if (elig[k] && (!m_hit || lvl_a[k] >= m_lvl)) begin
               m_hit = 1'b1;
               m_idx = SW'(k);
               m_lvl = lvl_a[k];
            end
         end
      end
   end

   always_comb begin
      hit     = 1'b1;
      hit_src = 1'b0;
      src     = m_idx;
      lvl     = LVL_TOP;
      if (exc[EXC_STK]) begin
         idx = IW'(EXC_STK);
      end else if (exc[EXC_ILL]) begin
         idx = IW'(EXC_ILL);
      end else if (exc[EXC_TRAP]) begin
         idx = IW'(EXC_TRAP);
      end else begin
         idx     = IW'(EXC_N) + IW'(m_idx);
         lvl     = m_lvl;
         hit     = m_hit;
         hit_src = m_hit;
      end
   end
endmodule

// File: rtl/svc_gate.sv
module svc_gate #(
   parameter int unsigned GAP = 6,
   localparam int unsigned CW = $clog2(GAP + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dec_strobe,
   input  logic grant,
   input  logic rep_run,
   input  logic lc_one,
   output logic open_ok,
   output logic early
);
   logic [CW-1:0] gap_cnt;
   logic [1:0]    drain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt <= CW'(GAP);
         drain   <= '0;
      end else begin
         if (grant)
            gap_cnt <= '0;
         else if (dec_strobe && gap_cnt != CW'(GAP))
            gap_cnt <= gap_cnt + 1'b1;

         if (rep_run && lc_one)
            drain <= 2'd2;
         else if (dec_strobe && drain != 2'd0)
            drain <= drain - 1'b1;
      end
   end

   assign open_ok = (gap_cnt == CW'(GAP)) && !rep_run && (drain == 2'd0);
   assign early   = gap_cnt < CW'(2);

   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rep_run && lc_one) |=> !open_ok); // R9
   AST_GAP_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> !open_ok); // R7
endmodule

// File: rtl/ctx_stack_ctl.sv
module ctx_stack_ctl #(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned DW = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_req,
   input  logic pop_req,
   input  logic err_clr,
   output logic push,
   output logic pop,
   output logic err_pend
);
   logic [DW-1:0] depth;
   logic          full;
   logic          empty;

   assign full  = depth == DW'(DEPTH);
   assign empty = depth == '0;
   assign push  = push_req && !full;
   assign pop   = pop_req && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth    <= '0;
         err_pend <= 1'b0;
      end else begin
         depth <= depth + DW'(push) - DW'(pop);
         if ((push_req && full) || (pop_req && empty))
            err_pend <= 1'b1;
         else if (err_clr)
            err_pend <= 1'b0;
      end
   end

   AST_STK_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full) |=> err_pend); // R11
   AST_STK_UNF: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty) |=> err_pend); // R11
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
   import irq_seq_pkg::*;
#(
   parameter int unsigned NSRC          = 4,
   parameter int unsigned AW            = 16,
   parameter logic [AW-1:0] VEC_BASE    = 16'h0100,
   parameter int unsigned STK_DEPTH     = 4,
   parameter int unsigned SPACING       = 4,
   parameter bit          TIE_LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_req,
   input  logic [2*NSRC-1:0] irq_lvl,
   input  logic [1:0]        sr_mask,
   input  logic              exc_illegal,
   input  logic              exc_trap,
   input  logic              dec_strobe,
   input  logic              call_dec,
   input  logic              rti_dec,
   input  logic              rep_run,
   input  logic              lc_one,
   output logic [NSRC-1:0]   irq_ack,
   output logic [1:0]        exc_ack,
   output logic              fetch_vec,
   output logic [AW-1:0]     vec_addr,
   output logic              mask_wr,
   output logic [1:0]        mask_val,
   output logic              stk_push,
   output logic              stk_pop
);
   localparam int unsigned NIDX = NSRC + EXC_N;
   localparam int unsigned IW   = $clog2(NIDX);
   localparam int unsigned SW   = (NSRC > 1) ? $clog2(NSRC) : 1;
   localparam int unsigned GAP  = SPACING + 2;

   if (NSRC < 1) begin : g_bad_nsrc
      $error("irq_seq_ctrl: NSRC must be at least 1");
   end
   if (AW < IW + 1) begin : g_bad_aw
      $error("irq_seq_ctrl: AW too narrow for the vector table");
   end
   if (STK_DEPTH < 1) begin : g_bad_depth
      $error("irq_seq_ctrl: STK_DEPTH must be at least 1");
   end
   if (SPACING < 1) begin : g_bad_spacing
      $error("irq_seq_ctrl: SPACING must be at least 1");
   end

   sq_state_t     state;
   logic          pick_hit, pick_src_hit;
   logic [SW-1:0] pick_src;
   logic [IW-1:0] pick_idx;
   lvl_t          pick_lvl;
   logic          gate_open, gate_early;
   logic          stk_err;
   logic          start, long_go;
   logic [IW-1:0] svc_idx;
   lvl_t          svc_lvl;
   logic          svc_open;

   irq_pick #(
      .NSRC(NSRC), .IW(IW), .TIE_LOW_FIRST(TIE_LOW_FIRST)
   ) u_pick (
      .req(irq_req), .lvl_flat(irq_lvl), .mask(sr_mask),
      .exc({exc_trap, exc_illegal, stk_err}),
      .hit(pick_hit), .hit_src(pick_src_hit), .src(pick_src),
      .idx(pick_idx), .lvl(pick_lvl)
   );

   svc_gate #(.GAP(GAP)) u_gate (
      .clk(clk), .rst_n(rst_n), .dec_strobe(dec_strobe), .grant(start),
      .rep_run(rep_run), .lc_one(lc_one),
      .open_ok(gate_open), .early(gate_early)
   );

   ctx_stack_ctl #(.DEPTH(STK_DEPTH)) u_stk (
      .clk(clk), .rst_n(rst_n), .push_req(long_go),
      .pop_req(dec_strobe && rti_dec),
      .err_clr(start && pick_idx == IW'(EXC_STK)),
      .push(stk_push), .pop(stk_pop), .err_pend(stk_err)
   );

   assign start   = (state == SQ_IDLE) && gate_open && pick_hit;
   assign long_go = dec_strobe && call_dec && svc_open && gate_early;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         svc_idx  <= '0;
         svc_lvl  <= '0;
         svc_open <= 1'b0;
         irq_ack  <= '0;
         exc_ack  <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (start) state <= SQ_CTL1;
            SQ_CTL1: state <= SQ_CTL2;
            SQ_CTL2: state <= SQ_VEC0;
            SQ_VEC0: state <= SQ_VEC1;
            default: state <= SQ_IDLE;
         endcase
         if (start) begin
            svc_idx  <= pick_idx;
            svc_lvl  <= pick_lvl;
            svc_open <= 1'b1;
         end else if (long_go) begin
            svc_open <= 1'b0;
         end
         irq_ack <= (start && pick_src_hit) ? (NSRC'(1) << pick_src) : '0;
         exc_ack <= {start && pick_idx == IW'(EXC_TRAP),
                     start && pick_idx == IW'(EXC_ILL)};
      end
   end

   assign fetch_vec = (state == SQ_VEC0) || (state == SQ_VEC1);
   assign vec_addr  = fetch_vec
                    ? VEC_BASE + AW'({svc_idx, 1'b0}) + AW'(state == SQ_VEC1)
                    : '0;
   assign mask_wr   = long_go;
   assign mask_val  = svc_lvl;

   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_ack, irq_ack})); // R4
   AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_VEC0) |=> (fetch_vec && vec_addr == $past(vec_addr) + AW'(1))); // R4
   AST_NO_FETCH_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (|{exc_ack, irq_ack}) |-> !fetch_vec); // R4
   AST_REP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rep_run |=> ({exc_ack, irq_ack} == '0)); // R8
   AST_LONG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> !mask_wr); // R5
endmodule

// File: tb/sim_irq_seq_ctrl.sv
`timescale 1ns/100ps
module sim_irq_seq_ctrl;
   localparam int NSRC = 4;
   localparam int AW   = 16;
   localparam logic [15:0] BASE = 16'h0100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC-1:0]   irq_req = '0;
   logic [2*NSRC-1:0] irq_lvl = '0;
   logic [1:0]        sr_mask = '0;
   logic exc_illegal = 0, exc_trap = 0, dec_strobe = 0, call_dec = 0;
   logic rti_dec = 0, rep_run = 0, lc_one = 0;
   logic [NSRC-1:0] irq_ack;
   logic [1:0]      exc_ack;
   logic            fetch_vec;
   logic [AW-1:0]   vec_addr;
   logic            mask_wr;
   logic [1:0]      mask_val;
   logic            stk_push, stk_pop;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_seq_ctrl #(.NSRC(NSRC), .AW(AW), .VEC_BASE(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .sr_mask(sr_mask), .exc_illegal(exc_illegal), .exc_trap(exc_trap),
      .dec_strobe(dec_strobe), .call_dec(call_dec), .rti_dec(rti_dec),
      .rep_run(rep_run), .lc_one(lc_one), .irq_ack(irq_ack), .exc_ack(exc_ack),
      .fetch_vec(fetch_vec), .vec_addr(vec_addr), .mask_wr(mask_wr),
      .mask_val(mask_val), .stk_push(stk_push), .stk_pop(stk_pop)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic set_lvl(input int s, input logic [1:0] v);
      irq_lvl[2*s +: 2] = v;
   endtask

   task automatic decodes(input int n);
      repeat (n) begin
         dec_strobe = 1'b1;
         @(negedge clk);
      end
      dec_strobe = 1'b0;
   endtask

   task automatic expect_none(input int n, input string rq);
      repeat (n) begin
         @(negedge clk);
         chk({rq, " no ack"}, {26'd0, exc_ack, irq_ack}, 32'd0);
      end
   endtask

   task automatic expect_service(input int idx, input logic [5:0] ack_exp, input string rq);
      logic [15:0] a0;
      a0 = BASE + 16'(2 * idx);
      @(negedge clk);
      chk({rq, " ack"}, {26'd0, exc_ack, irq_ack}, {26'd0, ack_exp});
      chk({rq, " no fetch in ctl1"}, fetch_vec, 0);
      irq_req = irq_req & ~irq_ack;
      if (exc_ack[0]) exc_illegal = 1'b0;
      if (exc_ack[1]) exc_trap = 1'b0;
      @(negedge clk);
      chk({rq, " no fetch in ctl2"}, fetch_vec, 0);
      @(negedge clk);
      chk({rq, " vec0"}, {fetch_vec, vec_addr}, {1'b1, a0});
      @(negedge clk);
      chk({rq, " vec1"}, {fetch_vec, vec_addr}, {1'b1, a0 + 16'd1});
      @(negedge clk);
      chk({rq, " fetch released"}, fetch_vec, 0);
   endtask

   task automatic t_reset;
      chk("R1 reset outputs", {fetch_vec, exc_ack, irq_ack, mask_wr, stk_push, stk_pop}, 0);
   endtask

   task automatic t_basic;
      sr_mask = 2'd1;
      set_lvl(2, 2'd2);
      irq_req = 4'b0100;
      expect_service(5, 6'b000100, "R4 basic");
      decodes(6);
   endtask

   task automatic t_mask;
      sr_mask = 2'd2;
      set_lvl(1, 2'd2);
      irq_req = 4'b0010;
      expect_none(4, "R2 equal level masked");
      set_lvl(1, 2'd3);
      expect_service(4, 6'b000010, "R2 higher level");
      decodes(6);
   endtask

   task automatic t_prio;
      sr_mask = 2'd3;
      set_lvl(3, 2'd3);
      irq_req = 4'b1000;
      exc_illegal = 1'b1;
      exc_trap = 1'b1;
      expect_service(1, 6'b010000, "R3 illegal first");
      decodes(6);
      expect_service(2, 6'b100000, "R3 trap next");
      decodes(6);
      expect_none(3, "R3 level 3 under mask 3");
      sr_mask = 2'd0;
      set_lvl(1, 2'd2);
      irq_req = 4'b1010;
      expect_service(6, 6'b001000, "R3 higher level wins");
      irq_req = '0;
      decodes(6);
      set_lvl(0, 2'd2);
      set_lvl(1, 2'd2);
      irq_req = 4'b0011;
      expect_service(3, 6'b000001, "R3 tie lower source");
      irq_req = '0;
      decodes(6);
   endtask

   task automatic t_long;
      sr_mask = 2'd0;
      set_lvl(2, 2'd1);
      irq_req = 4'b0100;
      expect_service(5, 6'b000100, "R5 service");
      dec_strobe = 1'b1;
      call_dec = 1'b1;
      #1;
      chk("R5 long conversion", {mask_wr, mask_val, stk_push}, {1'b1, 2'd1, 1'b1});
      @(negedge clk);
      #1;
      chk("R5 single conversion", {mask_wr, stk_push}, 0);
      @(negedge clk);
      call_dec = 1'b0;
      dec_strobe = 1'b0;
      decodes(6);
      irq_req = 4'b0100;
      expect_service(5, 6'b000100, "R6 service");
      decodes(2);
      dec_strobe = 1'b1;
      call_dec = 1'b1;
      #1;
      chk("R6 late call ignored", {mask_wr, stk_push}, 0);
      @(negedge clk);
      dec_strobe = 1'b0;
      call_dec = 1'b0;
      decodes(6);
   endtask

   task automatic t_rti;
      dec_strobe = 1'b1;
      rti_dec = 1'b1;
      #1;
      chk("R10 pop on return", stk_pop, 1);
      @(negedge clk);
      dec_strobe = 1'b0;
      rti_dec = 1'b0;
   endtask

   task automatic t_spacing;
      set_lvl(0, 2'd3);
      irq_req = 4'b0001;
      expect_service(3, 6'b000001, "R7 first");
      irq_req = 4'b0001;
      for (int k = 0; k < 6; k++) begin
         chk("R7 held during spacing", {26'd0, exc_ack, irq_ack}, 0);
         dec_strobe = 1'b1;
         @(negedge clk);
      end
      dec_strobe = 1'b0;
      chk("R7 held at window end", {26'd0, exc_ack, irq_ack}, 0);
      @(negedge clk);
      chk("R7 nested accepted", {26'd0, exc_ack, irq_ack}, 32'h1);
      irq_req = '0;
      repeat (3) @(negedge clk);
      decodes(6);
   endtask

   task automatic t_rep;
      rep_run = 1'b1;
      set_lvl(1, 2'd3);
      irq_req = 4'b0010;
      expect_none(4, "R8 repeat running");
      lc_one = 1'b1;
      expect_none(1, "R8 last repeat");
      rep_run = 1'b0;
      lc_one = 1'b0;
      expect_none(3, "R9 drain without decodes");
      for (int k = 0; k < 2; k++) begin
         chk("R9 held during drain", {26'd0, exc_ack, irq_ack}, 0);
         dec_strobe = 1'b1;
         @(negedge clk);
      end
      dec_strobe = 1'b0;
      chk("R9 held at drain end", {26'd0, exc_ack, irq_ack}, 0);
      @(negedge clk);
      chk("R9 accepted after drain", {26'd0, exc_ack, irq_ack}, 32'h2);
      irq_req = '0;
      repeat (3) @(negedge clk);
      decodes(6);
   endtask

   task automatic long_one(input logic exp_push, input string rq);
      set_lvl(0, 2'd1);
      irq_req = 4'b0001;
      expect_service(3, 6'b000001, rq);
      dec_strobe = 1'b1;
      call_dec = 1'b1;
      #1;
      chk(rq, {mask_wr, stk_push}, {1'b1, exp_push});
      @(negedge clk);
      dec_strobe = 1'b0;
      call_dec = 1'b0;
   endtask

   task automatic t_stack;
      sr_mask = 2'd0;
      for (int k = 0; k < 4; k++) begin
         long_one(1'b1, "R11 fill push");
         decodes(6);
      end
      long_one(1'b0, "R11 overflow push suppressed");
      decodes(5);
      expect_service(0, 6'b000000, "R11 overflow fault vector");
      decodes(6);
      for (int k = 0; k < 4; k++) begin
         dec_strobe = 1'b1;
         rti_dec = 1'b1;
         #1;
         chk("R10 pop", stk_pop, 1);
         @(negedge clk);
      end
      #1;
      chk("R11 underflow pop suppressed", stk_pop, 0);
      @(negedge clk);
      dec_strobe = 1'b0;
      rti_dec = 1'b0;
      expect_service(0, 6'b000000, "R11 underflow fault vector");
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_mask();
      t_prio();
      t_long();
      t_rti();
      t_spacing();
      t_rep();
      t_stack();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule